// File: doc/BRIEF.md
# Dual Time-Match Alarm Controller

This block watches a running calendar time and two programmed alarm times. When the time becomes equal to an armed alarm, the block sets that alarm's status flag. The flag stays set until software reads the status register. Each alarm has its own enable and its own flag, and both alarms may be armed and may fire together. A match is taken on the cycle in which equality first appears. A time value that stays equal for many cycles therefore produces one event.

An active-low interrupt request follows the flags when single-event signalling is selected. That selection needs three settings: the alarm's enable is set, the interrupt-mode bit is 0, and the frequency output is disabled. Once asserted, the request stays low while the time moves on. It is released only when the status read clears the flags. The flags themselves are set on every match, whatever the interrupt configuration is, so polling software sees the events as well.

The status-read strobe is a one-cycle pulse. The serial front end raises it at the point of a status read where the clear must take effect. The time counters, the serial bus and the frequency generator lie outside this block.

Top module: `alm_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both flags read 0 and `irq_n` reads 1.
- R2: When `alm_en[i]` is 1 and `time_now` becomes equal to alarm i (all 56 bits) after not being equal in the previous cycle, `alm_flag[i]` (bit 0 = alarm 0, bit 1 = alarm 1) reads 1 from the next clock edge on.
- R3: A time that stays equal to an alarm for many cycles sets the flag only once. After a clear, the flag stays 0 while equality continues.
- R4: An alarm whose enable is 0 never sets its flag, even when its value equals `time_now`.
- R5: A set flag stays set until a status read, and flags are set whatever the values of `irq_mode` and `fout_off` are.
- R6: A one-cycle `stat_rd` clears both flags at the next edge, and `irq_n` returns to 1 in that same cycle.
- R7: If a new match edge on alarm i arrives in the same cycle as `stat_rd`, `alm_flag[i]` ends up 1, so the event is kept.
- R8: `irq_n` is 0 exactly when a flag i is set with `alm_en[i]` = 1, `irq_mode` = 0 and `fout_off` = 1. Otherwise it is 1.
- R9: The two alarms work independently, and both flags may be set by the same edge.
- R10: Once low, `irq_n` stays low after the time has moved past the alarm value, until a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_now | input | 56 | Current time, seven 8-bit fields |
| alarm0_val | input | 56 | Alarm 0 compare value |
| alarm1_val | input | 56 | Alarm 1 compare value |
| alm_en | input | 2 | Per-alarm enable, bit i for alarm i |
| irq_mode | input | 1 | 0 selects single-event signalling |
| fout_off | input | 1 | 1 means the frequency output is disabled |
| stat_rd | input | 1 | Status-read clear strobe, one cycle |
| alm_flag | output | 2 | Sticky alarm flags, bit i for alarm i |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach from the ports is a fresh match edge that lands in the very cycle of the status-read strobe. A second hard case is a clear while the time is still held equal to the alarm, where the flag must not come back. Random time values spread over 56 bits would almost never hit either case. The stimulus therefore draws time and alarm values from a small pool of four words, so that equality and its edges occur often. It also pulses the read strobe at random, and directed steps place the coincident edge and the held-equal clear on purpose.

// File: rtl/alm_pkg.sv
// Package alm_pkg: shared sizes for the alarm controller.
// Assumes the time word is a fixed number of equal-width fields.
package alm_pkg;
    parameter int ALM_FIELDS = 7;
    parameter int ALM_FIELD_W = 8;
    parameter int ALM_TIME_W = ALM_FIELDS * ALM_FIELD_W;
    parameter int ALM_COUNT = 2;
    typedef logic [ALM_TIME_W-1:0] alm_time_t;
endpackage

// File: rtl/alm_match.sv
// Module alm_match: compares one alarm word with the current time field by
// field and emits a one-cycle pulse on the first cycle of equality.
// Assumes time_now and alarm_val are stable within a cycle. A disabled alarm
// never pulses, and its equality history is cleared.
module alm_match #(
    parameter int FIELDS = 7,
    parameter int FIELD_W = 8,
    localparam int TW = FIELDS * FIELD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [TW-1:0] alarm_val,
    input  logic [TW-1:0] time_now,
    output logic          hit
);
    logic [FIELDS-1:0] field_eq;
    logic              equal_now;
    logic              equal_q;

    // Per-field equality, one comparator per field.
    for (genvar f = 0; f < FIELDS; f++) begin : g_field
        assign field_eq[f] = (alarm_val[f*FIELD_W +: FIELD_W] ==
                              time_now[f*FIELD_W +: FIELD_W]);
    end

    // Armed equality: every field matches and the alarm is enabled.
    always_comb begin
        equal_now = enable && (&field_eq);
    end

    // Remember last cycle's armed equality so that only the edge counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            equal_q <= 1'b0;
        end else begin
            equal_q <= equal_now;
        end
    end

    // Match edge: equal now, not equal one cycle ago.
    always_comb begin
        hit = equal_now && !equal_q;
    end
endmodule

// File: rtl/alm_flags.sv
// Module alm_flags: holds the sticky per-alarm status flags.
// Assumes clr is a one-cycle strobe. A set request in the same cycle as a
// clear wins, so no event is lost.
module alm_flags #(
    parameter int COUNT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [COUNT-1:0] set_req,
    input  logic             clr,
    output logic [COUNT-1:0] flag
);
    logic [COUNT-1:0] flag_q;

    // One flag per alarm: set by a match edge, cleared by a status read.
    for (genvar i = 0; i < COUNT; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (set_req[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr) begin
                flag_q[i] <= 1'b0;
            end
        end
    end

    // Drive the registered flags out.
    always_comb begin
        flag = flag_q;
    end
endmodule

// File: rtl/alm_irq.sv
// Module alm_irq: forms the active-low interrupt request from the flags.
// Assumes single-event signalling is the only mode that drives the pin.
// Any other configuration leaves the request released.
module alm_irq #(
    parameter int COUNT = 2
) (
    input  logic [COUNT-1:0] flag,
    input  logic [COUNT-1:0] enable,
    input  logic             irq_mode,
    input  logic             fout_off,
    output logic             irq_n
);
    logic             single_evt;
    logic [COUNT-1:0] armed_flag;

    // Single-event mode needs interrupt mode 0 and the frequency output off.
    always_comb begin
        single_evt = !irq_mode && fout_off;
    end

    // A flag drives the pin only when its own alarm is enabled.
    always_comb begin
        armed_flag = flag & enable & {COUNT{single_evt}};
    end

    // Open-drain style output: low while any armed flag is set.
    always_comb begin
        irq_n = !(|armed_flag);
    end
endmodule

// File: rtl/alm_ctrl.sv
// Module alm_ctrl: top of the dual time-match alarm controller. It instantiates
// one comparator per alarm, the sticky flag store and the interrupt gate.
// Assumes synchronous active-low reset and a one-cycle stat_rd strobe.
module alm_ctrl
    import alm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ALM_TIME_W-1:0] time_now,
    input  logic [ALM_TIME_W-1:0] alarm0_val,
    input  logic [ALM_TIME_W-1:0] alarm1_val,
    input  logic [ALM_COUNT-1:0]  alm_en,
    input  logic                  irq_mode,
    input  logic                  fout_off,
    input  logic                  stat_rd,
    output logic [ALM_COUNT-1:0]  alm_flag,
    output logic                  irq_n
);
    alm_time_t            alarm_vals [ALM_COUNT];
    logic [ALM_COUNT-1:0] hit;

    // Gather the alarm words into an array for the generate loop.
    always_comb begin
        alarm_vals[0] = alarm0_val;
        alarm_vals[1] = alarm1_val;
    end

    for (genvar i = 0; i < ALM_COUNT; i++) begin : g_alarm
        alm_match #(
            .FIELDS (ALM_FIELDS),
            .FIELD_W(ALM_FIELD_W)
        ) u_match (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (alm_en[i]),
            .alarm_val(alarm_vals[i]),
            .time_now (time_now),
            .hit      (hit[i])
        );
    end

    alm_flags #(.COUNT(ALM_COUNT)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_req(hit),
        .clr    (stat_rd),
        .flag   (alm_flag)
    );

    alm_irq #(.COUNT(ALM_COUNT)) u_irq (
        .flag    (alm_flag),
        .enable  (alm_en),
        .irq_mode(irq_mode),
        .fout_off(fout_off),
        .irq_n   (irq_n)
    );
endmodule

// File: rtl/alm_ctrl_chk.sv
// Module alm_ctrl_chk: port-level properties of alm_ctrl, bound to every instance.
module alm_ctrl_chk
    import alm_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [ALM_TIME_W-1:0] time_now,
    input logic [ALM_TIME_W-1:0] alarm0_val,
    input logic [ALM_TIME_W-1:0] alarm1_val,
    input logic [ALM_COUNT-1:0]  alm_en,
    input logic                  irq_mode,
    input logic                  fout_off,
    input logic                  stat_rd,
    input logic [ALM_COUNT-1:0]  alm_flag,
    input logic                  irq_n
);
    // R1: reset leaves both flags clear and the request released.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (alm_flag == '0 && irq_n));

    // R4: flag 0 only rises after enabled equality in the previous cycle.
    a_r4_set_cause0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag[0]) |-> $past(alm_en[0] && alarm0_val == time_now));

    // R4: the same rule for flag 1.
    a_r4_set_cause1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag[1]) |-> $past(alm_en[1] && alarm1_val == time_now));

    // R5: without a read, a set flag stays set.
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_flag[0] && !stat_rd) |=> alm_flag[0]);

    // R6: a read with no equality present clears both flags.
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !(alm_en[0] && alarm0_val == time_now)
                 && !(alm_en[1] && alarm1_val == time_now))
        |=> (alm_flag == '0));

    // R8: the request is low only for an armed flag in single-event mode.
    a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (!irq_mode && fout_off && |(alm_flag & alm_en)));
endmodule

bind alm_ctrl alm_ctrl_chk u_alm_ctrl_chk (.*);

// File: tb/alm_ctrl_bench.sv
// Bench for alm_ctrl: directed corner cases followed by seeded random stimulus.
// It checks against a cycle model computed in the bench.
module alm_ctrl_bench;
    import alm_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [ALM_TIME_W-1:0] time_now = '0;
    logic [ALM_TIME_W-1:0] alarm0_val = '1;
    logic [ALM_TIME_W-1:0] alarm1_val = '1;
    logic [1:0]            alm_en = 2'b00;
    logic                  irq_mode = 1'b0;
    logic                  fout_off = 1'b1;
    logic                  stat_rd = 1'b0;
    logic [1:0]            alm_flag;
    logic                  irq_n;

    int tests = 0;
    int fails = 0;
    logic [1:0] exp_flag = 2'b00;
    logic [1:0] prev_eq = 2'b00;

    alm_ctrl u_alm_ctrl (.*);

    always #2 clk = ~clk;

    localparam logic [55:0] T0 = 56'h00_01_01_00_00_00_00;
    localparam logic [55:0] T1 = 56'h24_06_15_03_12_30_00;
    localparam logic [55:0] T2 = 56'h24_06_15_03_12_30_01;
    localparam logic [55:0] T3 = 56'h25_12_31_06_23_59_59;

    function automatic logic [55:0] pick(input int k);
        case (k % 4)
            0: return T0;
            1: return T1;
            2: return T2;
            default: return T3;
        endcase
    endfunction

    function automatic logic exp_irq_n(input logic [1:0] f);
        return !(|(f & alm_en) && !irq_mode && fout_off);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock step: update the model from the applied inputs, then compare at the falling edge.
    task automatic step();
        logic [1:0] eq;
        logic [1:0] nxt;
        eq[0] = alm_en[0] && (alarm0_val == time_now);
        eq[1] = alm_en[1] && (alarm1_val == time_now);
        nxt = (eq & ~prev_eq) | (stat_rd ? 2'b00 : exp_flag);
        if (!rst_n) begin
            nxt = 2'b00;
            eq = 2'b00;
        end
        @(posedge clk);
        prev_eq = eq;
        exp_flag = nxt;
        @(negedge clk);
        check("R2 flags", {6'd0, alm_flag}, {6'd0, exp_flag});
        check("R8 irq_n", {7'd0, irq_n}, {7'd0, exp_irq_n(exp_flag)});
        stat_rd = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240615));
        @(negedge clk);
        step();
        step();
        check("R1 reset flags", {6'd0, alm_flag}, 8'd0);
        check("R1 reset irq_n", {7'd0, irq_n}, 8'd1);
        rst_n = 1'b1;
        step();
        check("R1 after reset", {6'd0, alm_flag}, 8'd0);

        // R2: alarm 0 fires on equality
        alarm0_val = T1; alm_en = 2'b01; time_now = T0;
        step();
        time_now = T1;
        step();
        check("R2 flag0 set", {6'd0, alm_flag}, 8'd1);
        check("R8 irq low", {7'd0, irq_n}, 8'd0);
        step(); step();
        // R6 read clears, R3 no refire while held equal
        stat_rd = 1'b1;
        step();
        check("R6 read clears", {6'd0, alm_flag}, 8'd0);
        check("R6 irq released", {7'd0, irq_n}, 8'd1);
        step(); step();
        check("R3 held equal no refire", {6'd0, alm_flag}, 8'd0);

        // R4: disabled alarm ignored
        alm_en = 2'b00; time_now = T0;
        step();
        time_now = T1;
        step(); step();
        check("R4 disabled no flag", {6'd0, alm_flag}, 8'd0);
        check("R4 irq stays high", {7'd0, irq_n}, 8'd1);

        // R5: flag set even in periodic mode; irq stays released
        alm_en = 2'b01; irq_mode = 1'b1; time_now = T0;
        step();
        time_now = T1;
        step();
        check("R5 flag despite mode", {6'd0, alm_flag}, 8'd1);
        check("R8 no irq in mode 1", {7'd0, irq_n}, 8'd1);
        time_now = T2;
        step(); step();
        check("R5 sticky", {6'd0, alm_flag}, 8'd1);
        stat_rd = 1'b1;
        step();

        // R9 both fire together, R10 irq holds after time moves
        irq_mode = 1'b0; fout_off = 1'b1;
        alarm1_val = T3; alarm0_val = T3; alm_en = 2'b11; time_now = T0;
        step();
        time_now = T3;
        step();
        check("R9 both flags", {6'd0, alm_flag}, 8'd3);
        time_now = T0;
        step(); step(); step();
        check("R10 irq held low", {7'd0, irq_n}, 8'd0);
        fout_off = 1'b0;
        step();
        check("R8 fout on releases", {7'd0, irq_n}, 8'd1);
        fout_off = 1'b1;
        stat_rd = 1'b1;
        step();

        // R7: set and clear in the same cycle keeps the event
        alarm0_val = T2; alm_en = 2'b01; time_now = T2;
        stat_rd = 1'b1;
        step();
        check("R7 set beats clear", {6'd0, alm_flag}, 8'd1);
        stat_rd = 1'b1;
        step();

        // Random phase over a small value pool
        for (int n = 0; n < 4000; n++) begin
            time_now = pick($urandom);
            if ($urandom % 8 == 0) alarm0_val = pick($urandom);
            if ($urandom % 8 == 0) alarm1_val = pick($urandom);
            if ($urandom % 16 == 0) alm_en = 2'($urandom);
            if ($urandom % 16 == 0) irq_mode = 1'($urandom);
            if ($urandom % 16 == 0) fout_off = 1'($urandom);
            stat_rd = ($urandom % 6 == 0);
            step();
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule